// File: doc/BRIEF.md
# Double-Buffered PWM Channel

A single pulse-width-modulated output with a word-addressed register port, a built-in clock divider and a counter. Software sets a mode word, a duty value and a period value, then enables the channel. The counter advances on each count tick. The output takes its active level while the counter is below the duty value and its idle level otherwise. The idle level can be low or high. The counter either wraps to zero (edge alignment) or rises to the period value and falls back to zero (centre alignment).

Software changes the waveform of a running channel through a single staging register. The value written there waits until the current period ends. A mode bit then decides whether it becomes the new period or the new duty. A sticky event flag marks every period end and drives the interrupt line, so software can see when a staged value has landed. Two external tick strobes stand in for divided clocks shared with other channels.

Top module: `pwm_chan`

## Requirements
- R1: Word registers are decoded from bus_addr[4:2]: mode at 0x00 (11 bits), duty at 0x04 (20 bits), period at 0x08 (20 bits), counter at 0x0C (20 bits, read-only), staging at 0x10 (20 bits), control at 0x14 (bit 0 = enable) and status at 0x18 (bit 0 = period event). Writes to the writable ones read back unchanged.
- R2: Mode bits [3:0] pick the count tick. A value k from 0 to 10 gives one tick every 2^k clocks, with the first tick on the 2^k-th enabled clock. 0xB follows ext_tick_a, 0xC follows ext_tick_b, and 0xD to 0xF stop the counter.
- R3: With mode bit 8 clear, the counter steps 0, 1, ..., period-1 and then returns to 0. That return is the period end. A period of 0 or 1 keeps it at 0 and ends a period on every tick.
- R4: With mode bit 8 set, the counter rises from 0 to the period value and then falls back to 0. The tick that brings it back to 0 is the period end. A period of 0 ends a period on every tick.
- R5: pwm_out equals mode bit 9 (the idle level) unless the channel is enabled and counter < duty. In that case it is the inverse of bit 9.
- R6: A staging write is held until the next period end. At that end it replaces the period if mode bit 10 is set, and the duty otherwise. Duty and period stay unchanged at any other time except through direct writes.
- R7: Every period end sets the status flag, and irq follows it. A status read with bus_rd high clears the flag. A period end in the same cycle wins.
- R8: While the channel is disabled, the counter is held at 0, the output sits at the idle level, and a staged value stays pending.
- R9: After reset, every register reads 0 and pwm_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the status flag when reading status) |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| ext_tick_a | input | 1 | External count tick A |
| ext_tick_b | input | 1 | External count tick B |
| pwm_out | output | 1 | Waveform output |
| irq | output | 1 | Period-event flag |

## Verification
The checks assume that bus_wr and bus_rd are never high together. They also assume that software does not write duty or period in the cycle a period ends, since a direct write there would override the staged value. The assertions on counter holding further assume that the prescaler select is changed only while the channel is disabled. The stimulus respects all of this: it reconfigures only after writing the control register to 0, and it stages values instead of writing duty or period while counting. The external tick strobes are driven at the falling clock edge in fixed patterns.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CNT_W  = 20;
  localparam int DIV_W  = 10;
  localparam int MODE_W = 11;

  localparam logic [2:0] IX_MODE   = 3'd0;
  localparam logic [2:0] IX_DUTY   = 3'd1;
  localparam logic [2:0] IX_PERIOD = 3'd2;
  localparam logic [2:0] IX_COUNT  = 3'd3;
  localparam logic [2:0] IX_STAGE  = 3'd4;
  localparam logic [2:0] IX_CTRL   = 3'd5;
  localparam logic [2:0] IX_STAT   = 3'd6;

  localparam int B_CENTER = 8;
  localparam int B_IDLEHI = 9;
  localparam int B_TOPRD  = 10;

  localparam logic [3:0] SEL_EXT_A = 4'hB;
  localparam logic [3:0] SEL_EXT_B = 4'hC;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV_W = pwm_pkg::DIV_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] sel,
  input  logic       ext_a,
  input  logic       ext_b,
  output logic       tick
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [15:0]      div_tick;

  // one tick candidate per power-of-two exponent
  for (genvar g = 0; g < 16; g++) begin : g_exp
    if (g == 0) begin : g_one
      assign div_tick[g] = 1'b1;
    end else if (g <= DIV_W) begin : g_pow
      assign div_tick[g] = &div_q[g-1:0];
    end else begin : g_none
      assign div_tick[g] = 1'b0;
    end
  end

  always_comb begin
    div_d = en ? div_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  always_comb begin
    tick = 1'b0;
    if (en) begin
      if (int'(sel) <= DIV_W)        tick = div_tick[sel];
      else if (sel == pwm_pkg::SEL_EXT_A) tick = ext_a;
      else if (sel == pwm_pkg::SEL_EXT_B) tick = ext_b;
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = pwm_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             center,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic             bnd
);
  logic [CNT_W-1:0] cnt_d;
  logic             dn_q, dn_d;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_comb begin
    cnt_d = cnt;
    dn_d  = dn_q;
    bnd   = 1'b0;
    if (!en) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (tick) begin
      if (!center) begin
        dn_d = 1'b0;
        if (cnt_inc >= {1'b0, prd}) begin
          cnt_d = '0;
          bnd   = 1'b1;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end else if (!dn_q) begin
        if (cnt < prd) begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end else if (cnt == '0) begin
          bnd = 1'b1;
        end else begin
          cnt_d = cnt - 1'b1;
          if (cnt == CNT_W'(1)) bnd = 1'b1;
          else                  dn_d = 1'b1;
        end
      end else begin
        cnt_d = cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          bnd  = 1'b1;
          dn_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dn_q <= 1'b0;
    end else begin
      cnt  <= cnt_d;
      dn_q <= dn_d;
    end
  end

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R8
  AST_BND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> (cnt == '0)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt)); // R2
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int CNT_W  = pwm_pkg::CNT_W,
  parameter int MODE_W = pwm_pkg::MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [2:0]        idx,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              bnd,
  output logic              en,
  output logic [MODE_W-1:0] mode,
  output logic [CNT_W-1:0]  dty,
  output logic [CNT_W-1:0]  prd,
  output logic [CNT_W-1:0]  stage,
  output logic              flag
);
  import pwm_pkg::*;

  logic              en_d, pend_q, pend_d, flag_d;
  logic [MODE_W-1:0] mode_d;
  logic [CNT_W-1:0]  dty_d, prd_d, stage_d;
  logic              wr_dty, wr_prd;

  assign wr_dty = wr && (idx == IX_DUTY);
  assign wr_prd = wr && (idx == IX_PERIOD);

  always_comb begin
    en_d    = en;
    mode_d  = mode;
    dty_d   = dty;
    prd_d   = prd;
    stage_d = stage;
    pend_d  = pend_q;
    flag_d  = flag;
    // staged value lands only on a period end
    if (bnd && pend_q) begin
      if (mode[B_TOPRD]) prd_d = stage;
      else               dty_d = stage;
      pend_d = 1'b0;
    end
    if (wr) begin
      case (idx)
        IX_MODE:   mode_d = wdata[MODE_W-1:0];
        IX_DUTY:   dty_d  = wdata;
        IX_PERIOD: prd_d  = wdata;
        IX_STAGE: begin
          stage_d = wdata;
          pend_d  = 1'b1;
        end
        IX_CTRL:   en_d = wdata[0];
        default: ;
      endcase
    end
    if (bnd)                         flag_d = 1'b1;
    else if (rd && idx == IX_STAT)   flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      mode   <= '0;
      dty    <= '0;
      prd    <= '0;
      stage  <= '0;
      pend_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      en     <= en_d;
      mode   <= mode_d;
      dty    <= dty_d;
      prd    <= prd_d;
      stage  <= stage_d;
      pend_q <= pend_d;
      flag   <= flag_d;
    end
  end

  AST_DTY_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!bnd && !wr_dty) |=> $stable(dty)); // R6
  AST_PRD_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!bnd && !wr_prd) |=> $stable(prd)); // R6
  AST_FLAG_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> flag); // R7
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W  = pwm_pkg::CNT_W,
  parameter int DIV_W  = pwm_pkg::DIV_W,
  parameter int MODE_W = pwm_pkg::MODE_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ext_tick_a,
  input  logic        ext_tick_b,
  output logic        pwm_out,
  output logic        irq
);
  import pwm_pkg::*;

  logic              rs1_q, rst_sync_n;
  logic              en, tick, bnd, flag;
  logic [MODE_W-1:0] mode;
  logic [CNT_W-1:0]  dty, prd, stage, cnt;
  logic [2:0]        idx;
  logic              unused_bits;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs1_q      <= 1'b1;
      rst_sync_n <= rs1_q;
    end
  end

  assign idx         = bus_addr[4:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:CNT_W]};

  pwm_regs #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr(bus_wr), .rd(bus_rd), .idx(idx),
    .wdata(bus_wdata[CNT_W-1:0]), .bnd(bnd), .en(en), .mode(mode),
    .dty(dty), .prd(prd), .stage(stage), .flag(flag)
  );

  pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .sel(mode[3:0]),
    .ext_a(ext_tick_a), .ext_b(ext_tick_b), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .tick(tick),
    .center(mode[B_CENTER]), .prd(prd), .cnt(cnt), .bnd(bnd)
  );

  assign pwm_out = mode[B_IDLEHI] ^ (en && (cnt < dty));
  assign irq     = flag;

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IX_MODE:   bus_rdata = 32'(mode);
      IX_DUTY:   bus_rdata = 32'(dty);
      IX_PERIOD: bus_rdata = 32'(prd);
      IX_COUNT:  bus_rdata = 32'(cnt);
      IX_STAGE:  bus_rdata = 32'(stage);
      IX_CTRL:   bus_rdata = {31'b0, en};
      IX_STAT:   bus_rdata = {31'b0, flag};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: tb/tb_pwm_chan.sv
`timescale 1ns/1ps
module tb_pwm_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = 5'h0C;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_tick_a = 1'b0, ext_tick_b = 1'b0;
  logic        pwm_out, irq;

  int errs = 0, checks = 0;
  bit done = 0;
  int ext_mode = 0;
  int phase = 0;

  // reference state
  int unsigned m_cnt, m_div, m_mode, m_dty, m_prd, m_stage;
  bit m_dn, m_en, m_pend, m_flag;

  always #5 clk = ~clk;

  pwm_chan dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_tick_a(ext_tick_a), .ext_tick_b(ext_tick_b),
    .pwm_out(pwm_out), .irq(irq)
  );

  always @(negedge clk) begin
    phase <= phase + 1;
    ext_tick_a <= (ext_mode == 1) && (phase % 3 == 0);
    ext_tick_b <= (ext_mode == 2) && (phase % 2 == 1);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_mode = 0; m_dty = 0; m_prd = 0; m_stage = 0;
      m_dn = 0; m_en = 0; m_pend = 0; m_flag = 0;
    end else begin
      int sel, nc;
      bit tk, nd, b;
      sel = m_mode % 16;
      tk = 0;
      if (m_en) begin
        if (sel <= 10)      tk = ((m_div % (1 << sel)) == (1 << sel) - 1);
        else if (sel == 11) tk = ext_tick_a;
        else if (sel == 12) tk = ext_tick_b;
      end
      nc = m_cnt; nd = m_dn; b = 0;
      if (!m_en) begin
        nc = 0; nd = 0;
      end else if (tk) begin
        if (((m_mode >> 8) & 1) == 0) begin
          nd = 0;
          if (m_cnt + 1 >= m_prd) begin nc = 0; b = 1; end
          else nc = m_cnt + 1;
        end else if (!m_dn) begin
          if (m_cnt < m_prd) nc = m_cnt + 1;
          else if (m_cnt == 0) b = 1;
          else begin
            nc = m_cnt - 1;
            if (nc == 0) b = 1; else nd = 1;
          end
        end else begin
          nc = m_cnt - 1;
          if (nc == 0) begin b = 1; nd = 0; end
        end
      end
      m_div = m_en ? (m_div + 1) % 1024 : 0;
      if (b && m_pend) begin
        if ((m_mode >> 10) & 1) m_prd = m_stage; else m_dty = m_stage;
        m_pend = 0;
      end
      if (bus_wr) begin
        case (bus_addr)
          5'h00: m_mode = bus_wdata % 2048;
          5'h04: m_dty = bus_wdata % (1 << 20);
          5'h08: m_prd = bus_wdata % (1 << 20);
          5'h10: begin m_stage = bus_wdata % (1 << 20); m_pend = 1; end
          5'h14: m_en = bus_wdata[0];
          default: ;
        endcase
      end
      if (b) m_flag = 1;
      else if (bus_rd && bus_addr == 5'h18) m_flag = 0;
      m_cnt = nc; m_dn = nd;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit exp_out;
    exp_out = ((m_mode >> 9) & 1) ^ (m_en && (m_cnt < m_dty));
    chk(pwm_out == exp_out, "R5 R8 output level", 32'(pwm_out), 32'(exp_out));
    chk(irq == m_flag, "R7 period event", 32'(irq), 32'(m_flag));
    if (!bus_wr && bus_addr == 5'h0C)
      chk(bus_rdata == m_cnt, "R2 R3 R4 counter", bus_rdata, m_cnt);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0; bus_addr = 5'h0C;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    bus_addr = a; bus_rd = (a == 5'h18);
    #1;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
    cyc();
    bus_rd = 1'b0; bus_addr = 5'h0C;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(4);
    // R9 reset values
    rd(5'h00, 0, "R9 mode reset");
    rd(5'h04, 0, "R9 duty reset");
    rd(5'h08, 0, "R9 period reset");
    rd(5'h14, 0, "R9 ctrl reset");
    rd(5'h18, 0, "R9 status reset");
    chk(pwm_out == 1'b0, "R9 output reset", 32'(pwm_out), 0);
    // R1 readback, then edge-aligned run (R3, R5)
    wr(5'h04, 2);
    wr(5'h08, 5);
    wr(5'h00, 32'h0);
    rd(5'h04, 2, "R1 duty readback");
    rd(5'h08, 5, "R1 period readback");
    wr(5'h14, 1);
    rd(5'h14, 1, "R1 ctrl readback");
    run(25);
    // R6 duty staging
    wr(5'h10, 4);
    rd(5'h10, 4, "R1 staging readback");
    rd(5'h04, m_dty, "R6 duty before end");
    run(12);
    rd(5'h04, 4, "R6 duty after end");
    // R7 read clears
    rd(5'h18, 32'(m_flag), "R7 status read");
    run(3);
    // R6 period staging via bit 10
    wr(5'h00, 32'h400);
    rd(5'h00, 32'h400, "R1 mode readback");
    wr(5'h10, 3);
    run(12);
    rd(5'h08, 3, "R6 period after end");
    // R8 disabled: staged value stays pending
    wr(5'h14, 0);
    run(3);
    wr(5'h10, 7);
    run(6);
    rd(5'h08, 3, "R8 staged value held while off");
    // R4 centre aligned, idle high, divide by 4
    wr(5'h00, 32'h702);
    wr(5'h04, 2);
    wr(5'h14, 1);
    run(80);
    rd(5'h08, 7, "R6 pending value applied after enable");
    run(40);
    // R2 external tick A
    wr(5'h14, 0);
    ext_mode = 1;
    wr(5'h00, 32'h00B);
    wr(5'h08, 4);
    wr(5'h04, 1);
    wr(5'h14, 1);
    run(60);
    // R2 external tick B
    wr(5'h14, 0);
    ext_mode = 2;
    wr(5'h00, 32'h00C);
    wr(5'h14, 1);
    run(60);
    // R2 stopped select
    wr(5'h14, 0);
    ext_mode = 0;
    wr(5'h00, 32'h00E);
    wr(5'h14, 1);
    run(20);
    rd(5'h0C, 0, "R2 stopped select holds counter");
    // R2 largest divider
    wr(5'h14, 0);
    wr(5'h00, 32'h00A);
    wr(5'h08, 2);
    wr(5'h14, 1);
    run(3200);
    rd(5'h18, 32'(m_flag), "R7 status after slow run");
    run(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule